// File: doc/BRIEF.md
# Hart Local Interrupt Selector

This block decides which local interrupt a processor hart should take next. It holds the hart's pending-interrupt vector and a set of claimed interrupt lines. It combines the pending vector with the enable vector, the delegation mask, the current privilege level and the two global enable bits, and reports whether any interrupt qualifies and, if so, the index of the chosen one. Among qualifying interrupts the lowest-numbered one wins. Which interrupts qualify depends on whether each line is delegated and on the privilege level the hart runs at.

The pending vector changes only through a masked write. Bits selected by the mask take the supplied value and all other bits keep their state. In the cycle of the write, the value held before the write is returned. After every write, a hard-request line follows whether the new pending vector is nonzero. A claim port lets interrupt sources reserve lines. A claim succeeds only when none of the requested lines is already claimed.

The selection result can leave the block through a register stage (parameter `OUT_REG`, default 1) or combinationally. Privilege is encoded as user = 0, supervisor = 1, machine = 3. The value 2 counts as below machine mode and is not supervisor mode.

Top module: `hart_irq_arbiter`

## Requirements
- R1: An interrupt is a candidate only when its bit is set in both `pend_o` and `enable_i`. A pending bit whose enable is 0 is never selected.
- R2: A candidate whose `deleg_i` bit is 0 qualifies when `priv_i` is below 3, or when `priv_i` is 3 and `mie_i` is 1.
- R3: A candidate whose `deleg_i` bit is 1 qualifies when `priv_i` is 0, or when `priv_i` is 1 and `sie_i` is 1.
- R4: When one or more candidates qualify, `irq_valid_o` is 1 and `irq_idx_o` is the lowest bit position among them.
- R5: When no candidate qualifies, `irq_valid_o` is 0 and `irq_idx_o` is 0.
- R6: A cycle with `upd_valid_i` high makes `pend_o` become `(old & ~upd_mask_i) | (upd_value_i & upd_mask_i)` one cycle later. Without a write, `pend_o` keeps its value.
- R7: `upd_old_o` shows, in the same cycle as the write, the pending vector as it was before that write.
- R8: After a write, `hard_req_o` is 1 when the new pending vector is nonzero and 0 when it is zero. Without a write it keeps its value.
- R9: A claim whose `claim_bits_i` overlaps `claimed_o` is refused: `claim_ok_o` is 0 in that cycle and `claimed_o` does not change.
- R10: A claim with no overlap is granted: `claim_ok_o` is 1 in that cycle and `claimed_o` gains the requested bits on the next cycle.
- R11: After reset, the pending vector, the claimed set, `hard_req_o` and `irq_valid_o` are all 0. With `OUT_REG` = 1, the selection outputs reflect the inputs and pending state one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| upd_valid_i | input | 1 | Masked write of the pending vector |
| upd_mask_i | input | NIRQ | Bits affected by the write |
| upd_value_i | input | NIRQ | New value for the masked bits |
| upd_old_o | output | NIRQ | Pending vector before the current write |
| pend_o | output | NIRQ | Current pending vector |
| hard_req_o | output | 1 | Pending vector nonzero after the last write |
| claim_valid_i | input | 1 | Claim request |
| claim_bits_i | input | NIRQ | Lines requested by the claim |
| claim_ok_o | output | 1 | Claim granted this cycle |
| claimed_o | output | NIRQ | Set of claimed lines |
| enable_i | input | NIRQ | Per-line enable |
| deleg_i | input | NIRQ | Per-line delegation to supervisor |
| priv_i | input | 2 | Current privilege level |
| mie_i | input | 1 | Machine global enable |
| sie_i | input | 1 | Supervisor global enable |
| irq_valid_o | output | 1 | An interrupt qualifies |
| irq_idx_o | output | IDX_W | Index of the chosen interrupt |

## Verification
A corrupted pending register appears on `pend_o` and `upd_old_o` in the very next cycle. It also reaches the selection outputs one cycle after that when the output register is in use. A wrong claimed set changes `claimed_o` immediately and flips the grant/refuse decision of the next overlapping claim. A stale hard-request flop shows on `hard_req_o` right after the write that should have updated it. The bench compares every output with a behavioural model on every clock, so any of these faults is caught within one or two cycles of the stimulus that exposes it.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
    typedef logic [1:0] priv_t;

    localparam priv_t PRIV_USER = 2'd0;
    localparam priv_t PRIV_SUPV = 2'd1;
    localparam priv_t PRIV_MACH = 2'd3;
endpackage

// File: rtl/irq_pend_claim.sv
module irq_pend_claim #(
    parameter int NIRQ = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            upd_valid_i,
    input  logic [NIRQ-1:0] upd_mask_i,
    input  logic [NIRQ-1:0] upd_value_i,
    input  logic            claim_valid_i,
    input  logic [NIRQ-1:0] claim_bits_i,
    output logic [NIRQ-1:0] pend_o,
    output logic [NIRQ-1:0] claimed_o,
    output logic            hard_req_o,
    output logic            claim_ok_o
);
    typedef struct packed {
        logic [NIRQ-1:0] pend;
        logic [NIRQ-1:0] claimed;
        logic            hard;
    } state_t;

    state_t st_d, st_q;
    logic [NIRQ-1:0] merged;
    logic            grant;

    always_comb begin
        st_d   = st_q;
        merged = (st_q.pend & ~upd_mask_i) | (upd_value_i & upd_mask_i);
        grant  = claim_valid_i && ((st_q.claimed & claim_bits_i) == '0);
        if (upd_valid_i) begin
            st_d.pend = merged;
            st_d.hard = |merged;
        end
        if (grant) begin
            st_d.claimed = st_q.claimed | claim_bits_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o     = st_q.pend;
    assign claimed_o  = st_q.claimed;
    assign hard_req_o = st_q.hard;
    assign claim_ok_o = grant;
endmodule

// File: rtl/irq_qualify.sv
module irq_qualify #(
    parameter int NIRQ = 32
) (
    input  logic [NIRQ-1:0]     pend_i,
    input  logic [NIRQ-1:0]     enable_i,
    input  logic [NIRQ-1:0]     deleg_i,
    input  irq_sel_pkg::priv_t  priv_i,
    input  logic                mie_i,
    input  logic                sie_i,
    output logic [NIRQ-1:0]     elig_o
);
    import irq_sel_pkg::*;

    logic            mach_open;
    logic            supv_open;
    logic [NIRQ-1:0] cand;

    always_comb begin
        mach_open = (priv_i < PRIV_MACH) || ((priv_i == PRIV_MACH) && mie_i);
        supv_open = (priv_i < PRIV_SUPV) || ((priv_i == PRIV_SUPV) && sie_i);
        cand      = pend_i & enable_i;
        elig_o    = (cand & ~deleg_i & {NIRQ{mach_open}})
                  | (cand &  deleg_i & {NIRQ{supv_open}});
    end
endmodule

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
    parameter int NIRQ  = 32,
    parameter int IDX_W = $clog2(NIRQ)
) (
    input  logic [NIRQ-1:0]  vec_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = NIRQ - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
        valid_o = |vec_i;
    end
endmodule

// File: rtl/hart_irq_arbiter.sv
module hart_irq_arbiter #(
    parameter int NIRQ    = 32,
    parameter bit OUT_REG = 1'b1,
    localparam int IDX_W  = $clog2(NIRQ)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             upd_valid_i,
    input  logic [NIRQ-1:0]  upd_mask_i,
    input  logic [NIRQ-1:0]  upd_value_i,
    output logic [NIRQ-1:0]  upd_old_o,
    output logic [NIRQ-1:0]  pend_o,
    output logic             hard_req_o,
    input  logic             claim_valid_i,
    input  logic [NIRQ-1:0]  claim_bits_i,
    output logic             claim_ok_o,
    output logic [NIRQ-1:0]  claimed_o,
    input  logic [NIRQ-1:0]  enable_i,
    input  logic [NIRQ-1:0]  deleg_i,
    input  logic [1:0]       priv_i,
    input  logic             mie_i,
    input  logic             sie_i,
    output logic             irq_valid_o,
    output logic [IDX_W-1:0] irq_idx_o
);
    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pick_t;

    logic [NIRQ-1:0] pend_w;
    logic [NIRQ-1:0] elig_w;
    pick_t           pick_w;

    irq_pend_claim #(.NIRQ(NIRQ)) i_pend (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .upd_valid_i   (upd_valid_i),
        .upd_mask_i    (upd_mask_i),
        .upd_value_i   (upd_value_i),
        .claim_valid_i (claim_valid_i),
        .claim_bits_i  (claim_bits_i),
        .pend_o        (pend_w),
        .claimed_o     (claimed_o),
        .hard_req_o    (hard_req_o),
        .claim_ok_o    (claim_ok_o)
    );

    irq_qualify #(.NIRQ(NIRQ)) i_qual (
        .pend_i   (pend_w),
        .enable_i (enable_i),
        .deleg_i  (deleg_i),
        .priv_i   (priv_i),
        .mie_i    (mie_i),
        .sie_i    (sie_i),
        .elig_o   (elig_w)
    );

    irq_lsb_pick #(.NIRQ(NIRQ), .IDX_W(IDX_W)) i_pick (
        .vec_i   (elig_w),
        .valid_o (pick_w.valid),
        .idx_o   (pick_w.idx)
    );

    generate
        if (OUT_REG) begin : g_out_reg
            pick_t sel_d, sel_q;

            always_comb begin
                sel_d = pick_w;
            end

            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    sel_q <= '0;
                end else begin
                    sel_q <= sel_d;
                end
            end

            assign irq_valid_o = sel_q.valid;
            assign irq_idx_o   = sel_q.idx;
        end else begin : g_out_comb
            assign irq_valid_o = pick_w.valid;
            assign irq_idx_o   = pick_w.idx;
        end
    endgenerate

    assign pend_o    = pend_w;
    assign upd_old_o = pend_w;
endmodule

// File: rtl/hart_irq_arbiter_chk.sv
module hart_irq_arbiter_chk #(
    parameter int NIRQ    = 32,
    localparam int IDX_W  = $clog2(NIRQ)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             upd_valid_i,
    input logic [NIRQ-1:0]  upd_mask_i,
    input logic [NIRQ-1:0]  upd_value_i,
    input logic [NIRQ-1:0]  pend_o,
    input logic             hard_req_o,
    input logic             claim_valid_i,
    input logic [NIRQ-1:0]  claim_bits_i,
    input logic             claim_ok_o,
    input logic [NIRQ-1:0]  claimed_o,
    input logic             irq_valid_o,
    input logic [IDX_W-1:0] irq_idx_o
);
    AST_PEND_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_valid_i |=> pend_o == (($past(pend_o) & ~$past(upd_mask_i)) | ($past(upd_value_i) & $past(upd_mask_i)))); // R6
    AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !upd_valid_i |=> $stable(pend_o)); // R6
    AST_HARD_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_valid_i |=> hard_req_o == (pend_o != '0)); // R8
    AST_HARD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !upd_valid_i |=> $stable(hard_req_o)); // R8
    AST_CLAIM_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (claim_valid_i && !claim_ok_o) |=> $stable(claimed_o)); // R9
    AST_CLAIM_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        claim_ok_o |=> claimed_o == ($past(claimed_o) | $past(claim_bits_i))); // R10
    AST_IDLE_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_valid_o |-> irq_idx_o == '0); // R5
endmodule

bind hart_irq_arbiter hart_irq_arbiter_chk #(.NIRQ(NIRQ)) i_chk (.*);

// File: tb/test_hart_irq_arbiter.sv
`timescale 1ns/1ps
module test_hart_irq_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_mask = '0, upd_value = '0, upd_old, pend;
    logic        hard_req;
    logic        claim_valid = 1'b0;
    logic [31:0] claim_bits = '0, claimed;
    logic        claim_ok;
    logic [31:0] enable = '0, deleg = '0;
    logic [1:0]  priv = 2'd3;
    logic        mie = 1'b0, sie = 1'b0;
    logic        irq_valid;
    logic [4:0]  irq_idx;

    always #2 clk = ~clk;

    hart_irq_arbiter i_hart_irq_arbiter (
        .clk_i(clk), .rst_ni(rst_n),
        .upd_valid_i(upd_valid), .upd_mask_i(upd_mask), .upd_value_i(upd_value),
        .upd_old_o(upd_old), .pend_o(pend), .hard_req_o(hard_req),
        .claim_valid_i(claim_valid), .claim_bits_i(claim_bits),
        .claim_ok_o(claim_ok), .claimed_o(claimed),
        .enable_i(enable), .deleg_i(deleg), .priv_i(priv),
        .mie_i(mie), .sie_i(sie),
        .irq_valid_o(irq_valid), .irq_idx_o(irq_idx)
    );

    int    n_chk = 0, n_fail = 0;
    bit    done = 1'b0;
    logic [31:0] m_pend = '0, m_claim = '0;
    logic        m_hard = 1'b0, m_vld = 1'b0;
    int          m_idx = 0;
    string       m_tag = "R11";
    string       m_ctag = "R11";

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: search qualifying lines from the bottom
    task automatic ref_pick(input logic [31:0] p, en, dl, input logic [1:0] pr,
                            input logic mi, si, output logic v, output int ix);
        v = 1'b0; ix = 0;
        for (int i = 0; i < 32; i++) begin
            bit ok;
            if (dl[i]) ok = (pr == 2'd0) || (pr == 2'd1 && si);
            else       ok = (pr != 2'd3) || mi;
            if (!v && p[i] && en[i] && ok) begin v = 1'b1; ix = i; end
        end
    endtask

    task automatic step(input logic uv, input logic [31:0] um, uval,
                        input logic cv, input logic [31:0] cb,
                        input logic [31:0] en, dl, input logic [1:0] pr,
                        input logic mi, si, input string seltag);
        logic v; int ix; logic exp_ok; logic [31:0] nw;
        @(negedge clk);
        chk("R6", pend, m_pend);
        chk(m_ctag, claimed, m_claim);
        chk("R8", {31'd0, hard_req}, {31'd0, m_hard});
        chk(m_tag, {31'd0, irq_valid}, {31'd0, m_vld});
        chk(m_vld ? "R4" : "R5", {27'd0, irq_idx}, m_idx[31:0]);
        upd_valid = uv; upd_mask = um; upd_value = uval;
        claim_valid = cv; claim_bits = cb;
        enable = en; deleg = dl; priv = pr; mie = mi; sie = si;
        #1;
        if (uv) chk("R7", upd_old, m_pend);
        exp_ok = cv && ((m_claim & cb) == '0);
        chk(exp_ok ? "R10" : "R9", {31'd0, claim_ok}, {31'd0, exp_ok});
        ref_pick(m_pend, en, dl, pr, mi, si, v, ix);
        m_vld = v; m_idx = ix;
        if (seltag != "") m_tag = seltag;
        else if (!v) m_tag = "R5";
        else m_tag = dl[ix] ? "R3" : "R2";
        m_ctag = (cv && !exp_ok) ? "R9" : "R10";
        if (uv) begin
            nw = (m_pend & ~um) | (uval & um);
            m_pend = nw; m_hard = (nw != 0);
        end
        if (exp_ok) m_claim = m_claim | cb;
    endtask

    task automatic idle(input logic [31:0] en, dl, input logic [1:0] pr,
                        input logic mi, si, input string tag);
        step(1'b0, '0, '0, 1'b0, '0, en, dl, pr, mi, si, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11", pend, 32'd0);
        chk("R11", claimed, 32'd0);
        chk("R11", {31'd0, hard_req}, 32'd0);
        chk("R11", {31'd0, irq_valid}, 32'd0);
        rst_n = 1'b1;
        // write lines 9 and 11, machine mode with global enable
        step(1'b1, 32'hFFFF_FFFF, 32'h0000_0A00, 1'b0, '0, '1, '0, 2'd3, 1'b1, 1'b0, "R11");
        idle('1, '0, 2'd3, 1'b1, 1'b0, "R4");
        // R1: enable masks candidates
        idle(32'h0000_0800, '0, 2'd3, 1'b1, 1'b0, "R1");
        idle(32'h0000_0000, '0, 2'd3, 1'b1, 1'b0, "R1");
        // R2: non-delegated gating
        idle('1, '0, 2'd3, 1'b0, 1'b0, "R2");
        idle('1, '0, 2'd1, 1'b0, 1'b0, "R2");
        // R3: delegated gating
        idle('1, 32'h0000_0200, 2'd1, 1'b1, 1'b0, "R3");
        idle('1, 32'h0000_0200, 2'd1, 1'b1, 1'b1, "R3");
        idle('1, 32'hFFFF_FFFF, 2'd3, 1'b1, 1'b1, "R3");
        idle('1, 32'hFFFF_FFFF, 2'd0, 1'b0, 1'b0, "R3");
        // R6, R7, R8: partial writes and clear to zero
        step(1'b1, 32'h0000_0F00, 32'h0000_0100, 1'b0, '0, '1, '0, 2'd3, 1'b1, 1'b0, "");
        step(1'b1, 32'h0000_0100, 32'h0000_0000, 1'b0, '0, '1, '0, 2'd3, 1'b1, 1'b0, "");
        step(1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, '0, '1, '0, 2'd3, 1'b1, 1'b0, "");
        // R9, R10: claims
        step(1'b0, '0, '0, 1'b1, 32'h0000_0003, '1, '0, 2'd3, 1'b1, 1'b0, "");
        step(1'b0, '0, '0, 1'b1, 32'h0000_0006, '1, '0, 2'd3, 1'b1, 1'b0, "");
        step(1'b0, '0, '0, 1'b1, 32'h0000_0004, '1, '0, 2'd3, 1'b1, 1'b0, "");
        idle('1, '0, 2'd3, 1'b1, 1'b0, "");
        // mixed traffic
        for (int k = 0; k < 400; k++) begin
            logic [31:0] cb;
            cb = (32'd1 << $urandom_range(0, 31)) | (($urandom_range(0, 3) == 0) ? $urandom : 32'd0);
            step($urandom_range(0, 2) == 0, $urandom, $urandom & $urandom,
                 $urandom_range(0, 5) == 0, cb,
                 $urandom | $urandom, $urandom, 2'($urandom_range(0, 3)),
                 1'($urandom), 1'($urandom), "");
        end
        idle('1, '0, 2'd3, 1'b1, 1'b0, "");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R11 actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule